// File: doc/BRIEF.md
# Page Write Buffer with Busy Polling

This block sits between a byte-level serial slave front end and a nonvolatile array. A write transaction begins with an address load. The data bytes that follow are collected into a page buffer of 32 entries. A 5-bit offset counter picks the entry for each byte and wraps inside the page. The upper address bits stay fixed for the whole transaction.

When the stop strobe arrives, the block opens a self-timed write cycle, provided it holds at least one byte and the protection grant is high. During that cycle it drives only the buffer entries that were actually written out to the array, one per clock, and it holds `busy_o` high for a fixed number of clocks. The bus front end withholds the acknowledge to a slave address while `busy_o` is high. A master therefore learns that the cycle is over when an acknowledge comes back. Every load, byte and stop strobe that arrives during the cycle is dropped.

Top module: `page_wr_buf`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low.
- R2: The first data byte after a load is stored at the loaded address. Each later byte goes to the next offset, where the offset is the low 5 address bits.
- R3: Only the low 5 address bits advance, and they wrap from 31 to 0. Every array write in a cycle carries the upper 8 bits that were loaded.
- R4: If a transaction carries more than 32 bytes, the byte that arrives last for a given offset is the value written to that offset.
- R5: The array sees no write before the stop strobe. `arr_we_o` is high only while `busy_o` is high.
- R6: A stop accepted with a grant and at least one byte raises `busy_o` on the next clock. `busy_o` then stays high for exactly `CYCLE_CLKS` clocks.
- R7: Each offset written in the transaction receives exactly one array write per cycle. Offsets that were not written receive none.
- R8: A stop that arrives with no data bytes in the transaction leaves `busy_o` low and produces no array write.
- R9: While `busy_o` is high, the load, byte and stop strobes have no effect. They do not change the cycle length or the written data, and they do not open a later cycle.
- R10: A stop that arrives with `grant_i` low ends the transaction without any write cycle and discards the buffered bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the start address and begin a transaction |
| load_addr_i | input | 13 | Start address |
| byte_vld_i | input | 1 | A data byte was received |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | A stop condition was seen |
| grant_i | input | 1 | Protection grant, sampled together with the stop strobe |
| busy_o | output | 1 | A write cycle is in progress, so acknowledges are withheld |
| arr_we_o | output | 1 | Write strobe to the array |
| arr_addr_o | output | 13 | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
The assertions check four things on every cycle:
- A write strobe appears only while busy, and busy is only ever raised by a granted stop.
- Each busy window lasts exactly the configured number of clocks.
- The upper address bits stay constant across one write cycle.

The offset ordering, wrapping, last-byte-wins overwrite, one write per touched offset, and the ignoring of strobes during busy all depend on the data contents. Only the bench scenarios show these. They sweep every start offset against transaction lengths on both sides of a full page.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} cyc_st_e;
endpackage

// File: rtl/pwb_page_ctr.sv
module pwb_page_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     step_i,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic [PAGE_W-1:0]        off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      off_o  <= '0;
    end else if (load_i) begin
      page_o <= addr_i[ADDR_W-1:PAGE_W];
      off_o  <= addr_i[PAGE_W-1:0];
    end else if (step_i) begin
      off_o  <= off_o + 1'b1; // wraps inside page
    end
  end
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_o
);
  localparam int ENTRIES = 1 << PAGE_W;

  logic [DATA_W-1:0]  mem_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = wr_i && (wr_idx_i == PAGE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else begin
        if (hit) mem_q[g] <= wr_data_i;
        if (clr_i)    vld_q[g] <= 1'b0;
        else if (hit) vld_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_o     = |vld_q;
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer
  import pwb_pkg::*;
#(
  parameter int CYCLE_CLKS = 64,
  parameter int PAGE_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              scan_act_o,
  output logic [PAGE_W-1:0] scan_o
);
  localparam int CNT_W  = $clog2(CYCLE_CLKS) + 1;
  localparam int PAGES  = 1 << PAGE_W;

  cyc_st_e          st_q;
  logic [CNT_W-1:0] tmr_q;
  logic             last;

  assign last = (tmr_q == CNT_W'(CYCLE_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q  <= ST_BUSY;
          tmr_q <= '0;
        end
        ST_BUSY: begin
          if (last) st_q <= ST_IDLE;
          tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q == ST_BUSY);
  assign done_o     = busy_o && last;
  assign scan_act_o = busy_o && (tmr_q < CNT_W'(PAGES));
  assign scan_o     = tmr_q[PAGE_W-1:0];
endmodule

// File: rtl/page_wr_buf.sv
module page_wr_buf #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              busy, done, scan_act, rd_vld, any;
  logic              load_acc, byte_acc, stop_acc, launch, clr;
  logic [HI_W-1:0]   page;
  logic [PAGE_W-1:0] off, scan;
  logic [DATA_W-1:0] rd_data;

  // strobes are dropped while a cycle runs
  assign load_acc = load_i && !busy;
  assign byte_acc = byte_vld_i && !busy && !load_i;
  assign stop_acc = stop_i && !busy && !load_i && !byte_vld_i;
  assign launch   = stop_acc && grant_i && any;
  assign clr      = load_acc || (stop_acc && !launch) || done;

  pwb_page_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_acc),
    .addr_i (load_addr_i),
    .step_i (byte_acc),
    .page_o (page),
    .off_o  (off)
  );

  pwb_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (byte_acc),
    .wr_idx_i  (off),
    .wr_data_i (byte_i),
    .clr_i     (clr),
    .rd_idx_i  (scan),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_o     (any)
  );

  pwb_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS), .PAGE_W(PAGE_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .busy_o     (busy),
    .done_o     (done),
    .scan_act_o (scan_act),
    .scan_o     (scan)
  );

  assign busy_o     = busy;
  assign arr_we_o   = scan_act && rd_vld;
  assign arr_addr_o = {page, scan};
  assign arr_data_o = rd_data;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_W     = 5,
  parameter int CYCLE_CLKS = 1250000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              grant_i,
  input logic              busy_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o
);
  localparam int RUN_W = $clog2(CYCLE_CLKS + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R5
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  // R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == RUN_W'(CYCLE_CLKS)));

  // R10
  busy_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(stop_i) && $past(grant_i)));

  // R3
  page_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(arr_addr_o[ADDR_W-1:PAGE_W]));

  // R6
  busy_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < RUN_W'(CYCLE_CLKS)));
endmodule

bind page_wr_buf pwb_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .grant_i    (grant_i),
  .busy_o     (busy_o),
  .arr_we_o   (arr_we_o),
  .arr_addr_o (arr_addr_o)
);

// File: tb/sim_page_wr_buf.sv
`timescale 1ns/1ps
module sim_page_wr_buf;
  localparam int CYC = 40;

  logic        clk = 0, rst_n = 0;
  logic        load = 0, bvld = 0, stop = 0, grant = 0;
  logic [12:0] laddr = '0;
  logic [7:0]  bdat = '0;
  logic        busy, we;
  logic [12:0] waddr;
  logic [7:0]  wdat;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  page_wr_buf #(.CYCLE_CLKS(CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_addr_i(laddr),
    .byte_vld_i(bvld), .byte_i(bdat), .stop_i(stop), .grant_i(grant),
    .busy_o(busy), .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdat)
  );

  // monitor: values sampled at rising edge are those settled since the falling edge
  int         m_cnt [32];
  logic [7:0] m_dat [32];
  int         m_busy, m_total, m_badpg;
  logic [7:0] exp_pg;

  always @(posedge clk) begin
    if (busy) m_busy++;
    if (we) begin
      m_cnt[waddr[4:0]]++;
      m_dat[waddr[4:0]] = wdat;
      m_total++;
      if (waddr[12:5] !== exp_pg) m_badpg++;
    end
  end

  task automatic clr_mon();
    for (int i = 0; i < 32; i++) begin m_cnt[i] = 0; m_dat[i] = '0; end
    m_busy = 0; m_total = 0; m_badpg = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [12:0] a);
    @(negedge clk); load = 1; laddr = a; @(negedge clk); load = 0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); bvld = 1; bdat = d; @(negedge clk); bvld = 0;
  endtask
  task automatic pulse_stop(input logic g);
    @(negedge clk); stop = 1; grant = g; @(negedge clk); stop = 0; grant = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] dval(input int seed, input int i);
    return 8'((seed * 7 + i * 29 + 3) & 8'hff);
  endfunction

  task automatic run_txn(input int pg, input int start, input int n, input logic g, input int seed);
    int         e_hit [32];
    logic [7:0] e_dat [32];
    int         dmis, cmis, exp_busy, any;
    for (int i = 0; i < 32; i++) begin e_hit[i] = 0; e_dat[i] = '0; end
    for (int i = 0; i < n; i++) begin
      e_hit[(start + i) % 32] = 1;
      e_dat[(start + i) % 32] = dval(seed, i);
    end
    @(negedge clk); clr_mon(); exp_pg = 8'(pg);
    pulse_load(13'({pg[7:0], start[4:0]}));
    for (int i = 0; i < n; i++) pulse_byte(dval(seed, i));
    // R5: nothing written before the stop
    chk(m_total == 0 && m_busy == 0, "R5", m_total, 0);
    pulse_stop(g);
    idle(CYC + 6);
    any = (n > 0 && g) ? 1 : 0;
    exp_busy = any ? CYC : 0;
    dmis = 0; cmis = 0;
    for (int o = 0; o < 32; o++) begin
      if (m_cnt[o] != e_hit[o] * any) cmis++;
      if (any && e_hit[o] && m_dat[o] !== e_dat[o]) dmis++;
    end
    if (n == 0)       chk(m_busy == 0 && m_total == 0, "R8", m_busy, 0);
    else if (!g)      chk(m_busy == 0 && m_total == 0, "R10", m_busy, 0);
    else begin
      chk(m_busy == exp_busy, "R6", m_busy, exp_busy);
      chk(cmis == 0, "R7", cmis, 0);
      chk(m_badpg == 0, "R3", m_badpg, 0);
      if (n > 32) chk(dmis == 0, "R4", dmis, 0);
      else        chk(dmis == 0, "R2", dmis, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    clr_mon(); exp_pg = '0;
    idle(3);
    // R1
    chk(busy == 0 && we == 0, "R1", int'(busy), 0);
    rst_n = 1;
    idle(2);
    chk(busy == 0 && we == 0, "R1", int'(we), 0);

    // sweep every start offset against lengths around a page
    for (int s = 0; s < 32; s++) begin
      run_txn((s * 13 + 5) & 8'hff, s, 1, 1'b1, s);
      run_txn((s * 13 + 6) & 8'hff, s, 3, 1'b1, s + 1);
      run_txn((s * 13 + 7) & 8'hff, s, 32, 1'b1, s + 2);
      run_txn((s * 13 + 8) & 8'hff, s, 33, 1'b1, s + 3);
      run_txn((s * 13 + 9) & 8'hff, s, 45, 1'b1, s + 4);
    end

    // R3: wrap from offset 30 into 0,1 at a fixed upper page
    run_txn(8'hA5, 30, 4, 1'b1, 99);
    chk(m_cnt[30] == 1 && m_cnt[31] == 1 && m_cnt[0] == 1 && m_cnt[1] == 1 && m_cnt[2] == 0,
        "R3", m_total, 4);

    // R8 / R10
    run_txn(8'h11, 4, 0, 1'b1, 7);
    run_txn(8'h12, 4, 5, 1'b0, 8);
    // R10: discarded bytes do not leak into a later empty stop
    @(negedge clk); clr_mon();
    pulse_stop(1'b1); idle(CYC + 4);
    chk(m_busy == 0 && m_total == 0, "R10", m_total, 0);

    // R9: strobes during busy are dropped
    @(negedge clk); clr_mon(); exp_pg = 8'h3C;
    pulse_load({8'h3C, 5'd8});
    pulse_byte(8'h41); pulse_byte(8'h42); pulse_byte(8'h43);
    pulse_stop(1'b1);
    pulse_load({8'h77, 5'd0});
    pulse_byte(8'hEE);
    pulse_stop(1'b1);
    idle(CYC + 4);
    chk(m_busy == CYC, "R9", m_busy, CYC);
    chk(m_total == 3 && m_dat[8] == 8'h41 && m_dat[10] == 8'h43 && m_cnt[0] == 0,
        "R9", m_total, 3);
    chk(m_badpg == 0, "R9", m_badpg, 0);
    @(negedge clk); clr_mon();
    pulse_stop(1'b1); idle(CYC + 4);
    chk(m_busy == 0 && m_total == 0, "R9", m_busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule